// File: doc/BRIEF.md
# Dual-Counter PWM Generator

This block turns a duty word from a speed controller into a single pulse-width-modulated output bit. The period is fixed at 2^N clocks. Two counters of their own produce the waveform. An incrementing counter times the high phase up to the active duty value. A decrementing counter is loaded with the remaining part of the period and times the low phase down to its last cycle. Each counter hands control to the other when it reaches its terminal value.

The controller presents a duty word together with a one-cycle load strobe. The word is clamped to full scale and held as pending. It becomes the active duty only at the next period boundary, which is the start of a high phase, so a period that is already running always completes with the duty it started with. If several words arrive within one period, the last one wins. A duty of zero holds the output low and a full-scale duty holds it high, with no stray pulses.

Top module: `pwm_dc_gen`

## Requirements
- R1: While `rst` is high, and after it is released until a nonzero duty is loaded, `pwm_o` is low. Reset clears both counters, the pending word and the active duty (the active duty becomes 0).
- R2: For an active duty d with 0 < d < 2^N, `pwm_o` is high for exactly d consecutive clocks in every period.
- R3: For the same duty d, `pwm_o` is low for exactly 2^N - d consecutive clocks, so each period lasts exactly 2^N clocks.
- R4: A duty of 1 gives a single-clock high pulse per period, and a duty of 2^N - 1 gives a single-clock low gap per period.
- R5: A duty of 0 keeps `pwm_o` constantly low across period boundaries, with no pulses.
- R6: A duty of 2^N (full scale) keeps `pwm_o` constantly high across period boundaries, with no gaps.
- R7: A duty word greater than 2^N behaves exactly like 2^N.
- R8: A word loaded during a period does not change that period. It takes effect from the start of the next high phase.
- R9: When several words are loaded within one period, only the last one is applied at the next boundary.
- R10: Asserting `rst` while the output is high forces `pwm_o` low on the next clock, and it stays low after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | CNT_W+1 | Requested high time in clocks (0 to 2^CNT_W; larger values are clamped) |
| load_i | input | 1 | One-cycle strobe that captures `duty_i` as the pending duty |
| pwm_o | output | 1 | PWM output, high during the high phase |

## Verification
The bench measures whole high and low runs clock by clock. This catches an off-by-one in either counter: a high run of d±1, or a period that is not 2^N long. Duties of 0, 1, 2^N-1, 2^N and an over-range word go after the hand-over edges. A design that mishandles a zero-length phase shows a one-clock glitch at the boundary, and one that forgets to clamp wraps an over-range word into a short pulse. A word loaded in the middle of a high phase must leave that period's run untouched; a design that applies it at once stretches the current pulse. Back-to-back loads and a reset during a high phase show whether stale pending or counter state survives.

// File: rtl/pwm_dc_pkg.sv
package pwm_dc_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  // Requested high time limited to one full period.
  function automatic int unsigned clamp_duty(input int unsigned d, input int unsigned full);
    return (d > full) ? full : d;
  endfunction

  // Clocks left for the low phase once the high phase is done.
  function automatic int unsigned low_span(input int unsigned d, input int unsigned full);
    return full - clamp_duty(d, full);
  endfunction

endpackage

// File: rtl/pwm_dc_duty_hold.sv
module pwm_dc_duty_hold
  import pwm_dc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_i,
  input  logic [CNT_W:0]       duty_i,
  input  logic                 take_i,
  output logic [CNT_W:0]       act_o,
  output logic [CNT_W:0]       next_o
);
  localparam int unsigned DW   = CNT_W + 1;
  localparam int unsigned FULL = 1 << CNT_W;

  logic [DW-1:0] pend_q;
  logic [DW-1:0] act_q;
  logic          pend_vld_q;
  logic [DW-1:0] in_clamped;

  assign in_clamped = DW'(clamp_duty(32'(duty_i), FULL));

  // A load in the boundary cycle is applied to the period that starts there.
  always_comb begin
    if (load_i)          next_o = in_clamped;
    else if (pend_vld_q) next_o = pend_q;
    else                 next_o = act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      act_q      <= '0;
      pend_vld_q <= 1'b0;
    end else if (take_i) begin
      act_q      <= next_o;
      pend_vld_q <= 1'b0;
    end else if (load_i) begin
      pend_q     <= in_clamped;
      pend_vld_q <= 1'b1;
    end
  end

  assign act_o = act_q;

endmodule

// File: rtl/pwm_dc_up_cnt.sv
module pwm_dc_up_cnt #(
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [DW-1:0] limit_i,
  output logic [DW-1:0] cnt_o,
  output logic          done_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (start_i) cnt_q <= DW'(1);
    else if (step_i)  cnt_q <= cnt_q + DW'(1);
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == limit_i);

endmodule

// File: rtl/pwm_dc_dn_cnt.sv
module pwm_dc_dn_cnt #(
  parameter int unsigned DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          step_i,
  output logic [DW-1:0] cnt_o,
  output logic          last_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_q - DW'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q <= DW'(1));

endmodule

// File: rtl/pwm_dc_gen.sv
module pwm_dc_gen
  import pwm_dc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W:0]   duty_i,
  input  logic             load_i,
  output logic             pwm_o
);
  localparam int unsigned DW   = CNT_W + 1;
  localparam int unsigned FULL = 1 << CNT_W;
  localparam logic [DW-1:0] FULL_DW = DW'(FULL);

  phase_e        ph_q;
  logic          ph_high;
  logic [DW-1:0] act_duty;
  logic [DW-1:0] next_duty;
  logic [DW-1:0] low_len;
  logic [DW-1:0] up_cnt;
  logic [DW-1:0] dn_cnt;
  logic          up_done;
  logic          dn_last;

  // Named internal events, also watched by the checker.
  logic          hi_done;
  logic          lo_last;
  logic          period_start;
  logic          next_is_zero;

  assign ph_high      = (ph_q == PH_HIGH);
  assign hi_done      = ph_high && up_done;
  assign lo_last      = !ph_high && dn_last;
  assign low_len      = DW'(low_span(32'(act_duty), FULL));
  assign period_start = lo_last || (hi_done && (low_len == '0));
  assign next_is_zero = (next_duty == '0);

  pwm_dc_duty_hold #(.CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .duty_i (duty_i),
    .take_i (period_start),
    .act_o  (act_duty),
    .next_o (next_duty)
  );

  pwm_dc_up_cnt #(.DW(DW)) u_hi_cnt (
    .clk     (clk),
    .rst     (rst),
    .start_i (period_start && !next_is_zero),
    .step_i  (ph_high && !hi_done),
    .limit_i (act_duty),
    .cnt_o   (up_cnt),
    .done_o  (up_done)
  );

  pwm_dc_dn_cnt #(.DW(DW)) u_lo_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     ((period_start && next_is_zero) || (hi_done && !period_start)),
    .load_val_i (period_start ? FULL_DW : low_len),
    .step_i     (!ph_high && !lo_last),
    .cnt_o      (dn_cnt),
    .last_o     (dn_last)
  );

  always_ff @(posedge clk) begin
    if (rst)               ph_q <= PH_LOW;
    else if (period_start) ph_q <= next_is_zero ? PH_LOW : PH_HIGH;
    else if (hi_done)      ph_q <= PH_LOW;
  end

  assign pwm_o = ph_high;

endmodule

// File: rtl/pwm_dc_gen_chk.sv
module pwm_dc_gen_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           pwm_o,
  input logic           ph_high,
  input logic           hi_done,
  input logic           period_start,
  input logic [CNT_W:0] up_cnt,
  input logic [CNT_W:0] act_duty
);
  localparam int unsigned DW     = CNT_W + 1;
  localparam int unsigned PERIOD = 1 << CNT_W;

  logic [DW-1:0] per_cnt;
  logic          seen_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt    <= '0;
      seen_start <= 1'b0;
    end else if (period_start) begin
      per_cnt    <= '0;
      seen_start <= 1'b1;
    end else begin
      per_cnt    <= per_cnt + DW'(1);
    end
  end

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !pwm_o);

  p_edge_at_phase_end_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (pwm_o != $past(pwm_o))) |-> $past(hi_done || period_start));

  p_hi_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    ph_high |-> ((up_cnt != '0) && (up_cnt <= act_duty)));

  p_period_len_r3: assert property (@(posedge clk) disable iff (rst)
    (period_start && seen_start) |-> (per_cnt == DW'(PERIOD - 1)));

  p_zero_low_r5: assert property (@(posedge clk) disable iff (rst)
    (act_duty == '0) |-> !pwm_o);

  p_full_high_r6: assert property (@(posedge clk) disable iff (rst)
    (act_duty == DW'(PERIOD)) |-> pwm_o);

  p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    act_duty <= DW'(PERIOD));

  p_defer_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (act_duty != $past(act_duty))) |-> $past(period_start));

endmodule

bind pwm_dc_gen pwm_dc_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwm_o        (pwm_o),
  .ph_high      (ph_high),
  .hi_done      (hi_done),
  .period_start (period_start),
  .up_cnt       (up_cnt),
  .act_duty     (act_duty)
);

// File: tb/test_pwm_dc_gen.sv
module test_pwm_dc_gen;
  localparam int N  = 8;
  localparam int DW = N + 1;
  localparam int P  = 1 << N;

  logic          clk  = 1'b0;
  logic          rst  = 1'b1;
  logic          load = 1'b0;
  logic [DW-1:0] duty = '0;
  logic          pwm;
  int            checks = 0;
  int            fails  = 0;

  always #2 clk = ~clk;

  pwm_dc_gen #(.CNT_W(N)) i_pwm_dc_gen (
    .clk    (clk),
    .rst    (rst),
    .duty_i (duty),
    .load_i (load),
    .pwm_o  (pwm)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input int d);
    @(negedge clk);
    duty = DW'(d);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_rise(output bit found);
    bit prev;
    found = 1'b0;
    prev  = pwm;
    for (int i = 0; i < 4 * P; i++) begin
      @(negedge clk);
      if (!prev && pwm) begin
        found = 1'b1;
        break;
      end
      prev = pwm;
    end
  endtask

  // Starts on a high sample; ends on the first high sample of the next period.
  task automatic count_runs(output int hi, output int lo);
    hi = 0;
    lo = 0;
    while (pwm && hi < 2 * P) begin
      hi++;
      @(negedge clk);
    end
    while (!pwm && lo < 2 * P) begin
      lo++;
      @(negedge clk);
    end
  endtask

  task automatic level_hold(input bit exp, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm != exp) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_duty(input int d, input string tag);
    bit f;
    int hi, lo;
    apply(d);
    wait_rise(f);
    chk(f, {tag, " rising edge seen"}, int'(f), 1);
    count_runs(hi, lo);
    chk(hi == d, {tag, " high run (R2)"}, hi, d);
    chk(lo == P - d, {tag, " low run (R3)"}, lo, P - d);
  endtask

  task automatic test_reset_r1();
    int bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (pwm) bad++;
    end
    chk(bad == 0, "R1 low during reset", bad, 0);
    rst = 1'b0;
    level_hold(1'b0, 300, "R1 low after release with no load");
  endtask

  task automatic test_defer_r8();
    bit f;
    int hi, lo, k;
    apply(64);
    wait_rise(f);
    count_runs(hi, lo);
    hi = 1;
    lo = 0;
    k  = 0;
    while (1) begin
      @(negedge clk);
      k++;
      if (k == 10) begin
        duty = DW'(200);
        load = 1'b1;
      end else begin
        load = 1'b0;
      end
      if (!pwm) break;
      hi++;
      if (hi > 2 * P) break;
    end
    lo = 1;
    while (lo < 2 * P) begin
      @(negedge clk);
      if (pwm) break;
      lo++;
    end
    chk(hi == 64, "R8 current high run kept", hi, 64);
    chk(lo == P - 64, "R8 current low run kept", lo, P - 64);
    count_runs(hi, lo);
    chk(hi == 200, "R8 new duty from next period", hi, 200);
  endtask

  task automatic test_last_wins_r9();
    bit f;
    int hi, lo;
    apply(30);
    apply(100);
    wait_rise(f);
    count_runs(hi, lo);
    chk(hi == 100, "R9 last load applied", hi, 100);
  endtask

  task automatic test_zero_r5();
    apply(0);
    repeat (2 * P) @(negedge clk);
    level_hold(1'b0, 2 * P, "R5 zero duty stays low");
  endtask

  task automatic test_full_r6();
    apply(P);
    repeat (2 * P) @(negedge clk);
    level_hold(1'b1, 2 * P, "R6 full duty stays high");
  endtask

  task automatic test_clamp_r7();
    apply(0);
    repeat (2 * P) @(negedge clk);
    apply(P + 44);
    repeat (2 * P) @(negedge clk);
    level_hold(1'b1, 2 * P, "R7 over-range duty stays high");
  endtask

  task automatic test_mid_reset_r10();
    bit f;
    apply(128);
    wait_rise(f);
    rst = 1'b1;
    @(negedge clk);
    chk(pwm == 1'b0, "R10 low after reset in high phase", int'(pwm), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    level_hold(1'b0, P + 44, "R10 stays low after release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset_r1();
    run_duty(64, "R2/R3 d=64");
    run_duty(128, "R2/R3 d=128");
    run_duty(200, "R2/R3 d=200");
    run_duty(1, "R4 d=1");
    run_duty(P - 1, "R4 d=max-1");
    test_zero_r5();
    test_full_r6();
    test_clamp_r7();
    test_defer_r8();
    test_last_wins_r9();
    test_mid_reset_r10();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule